// File: doc/BRIEF.md
# Stop-Mode Wake and System Clock Control

This block holds the eight-bit control register that decides how a small microcontroller core leaves its stop state and how fast its system and timer clock runs. The core writes the register over a simple write port. It selects the bank and the register address, and only one bank/address pair reaches it. A single-cycle stop request puts the block to sleep. While asleep, the system clock enable stays low and only the wake detector runs from the free-running oscillator clock.

The wake source is either one port pin or the NOR of a group of port-2 bits. It passes through a two-stage synchronizer and is compared with a programmed level. When the source matches, the block raises a reset request for the core. The request lasts either a long or a short number of oscillator cycles. The block also sets a sticky flag that lets software tell a stop recovery apart from a power-on start. The clock enable produces one pulse per period: the period is the crystal divided by 2, or the undivided crystal, with an optional further divide by 16 that clears itself on every wake.

Top module: `stop_wake_ctl`

## Requirements
- R1: A read returns the recovery flag in bit 7, and bits 6 to 0 always read as 0.
- R2: After power-on reset the flag is 0 and the configuration is: level low, long delay on, source 000, crystal/2, divide-by-16 off. The clock enable therefore pulses once every 2 cycles.
- R3: A write changes the register only when the bank is 0xF and the address is 0x0B. Writes to any other bank or address leave the clock pattern unchanged.
- R4: Written bits are: bit 6 wake level, bit 5 delay enable, bits 4..2 source, bit 1 full crystal, bit 0 divide-by-16. While the core runs, the clock enable pulses once every (bit1 ? 1 : 2) * (bit0 ? 16 : 1) cycles.
- R5: A stop request while running puts the block to sleep in the next cycle, and the clock enable stays low while asleep.
- R6: The source codes are: 001 to 100 select port 3 pins 0 to 3; 101 selects port 2 pin 7; 110 selects NOR of port 2 bits 3..0; 111 selects NOR of port 2 bits 7..0. A wake occurs when the selected value equals bit 6. The reset request rises on the third clock edge after the pin change, and no other pin can cause a wake.
- R7: With source 000, no pin activity ends sleep. Only the external or power-on reset ends it.
- R8: On a wake, the reset request stays high for 64 cycles when the delay bit is 1 and for 2 cycles when it is 0. The clock enable stays low during that time and resumes afterwards.
- R9: A wake sets the flag. An external reset leaves the flag unchanged. Only power-on reset clears it.
- R10: A wake clears the divide-by-16 bit and keeps the other written bits.
- R11: An external reset returns bits 6 to 0 to their power-on defaults and ends sleep.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running oscillator clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| ext_rst_n | input | 1 | External reset, sampled on clk, active low |
| wr_en | input | 1 | Register write strobe |
| wr_bank | input | 4 | Register bank of the write |
| wr_addr | input | 8 | Register address of the write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read value: flag in bit 7, zeros below |
| stop_req | input | 1 | One-cycle request to enter stop |
| p3_in | input | 4 | Port 3 pins 3..0 |
| p2_in | input | 8 | Port 2 pins 7..0 |
| wake_rst | output | 1 | Reset request to the core after a wake |
| sclk_en | output | 1 | System/timer clock enable pulse |
| asleep | output | 1 | High while in stop |

## Verification
The assertions assume four things about the inputs. Stop requests arrive only while the core runs. Writes do not happen while asleep. The external reset is a clean synchronous level. The port pins may be asynchronous because they pass through the synchronizer. The stimulus keeps to these assumptions: it drives every input half a cycle away from the sampling edge, and it writes only while the core runs. Before each stop it holds the pins at the inactive level for several cycles, so the synchronizer holds no stale active value. The sweep covers all seven sources, both levels and both delay settings. For each case it computes the inactive and active pin patterns, with non-selected pins held at the active level as a decoy.

// File: rtl/stop_wake_ctl.sv
module stop_wake_ctl #(
  parameter int         LONG_HOLD  = 64,
  parameter int         SHORT_HOLD = 2,
  parameter logic [3:0] REG_BANK   = 4'hF,
  parameter logic [7:0] REG_ADDR   = 8'h0B
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       ext_rst_n,
  input  logic       wr_en,
  input  logic [3:0] wr_bank,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       stop_req,
  input  logic [3:0] p3_in,
  input  logic [7:0] p2_in,
  output logic       wake_rst,
  output logic       sclk_en,
  output logic       asleep
);
  localparam int MAXH = (LONG_HOLD > SHORT_HOLD) ? LONG_HOLD : SHORT_HOLD;
  localparam int HW   = $clog2(MAXH) + 1;

  logic       lvl_q, dly_q, full_q, d16_q, flag_q;
  logic [2:0] src_q;
  logic       asleep_q, hold_q;
  logic [HW-1:0] hold_cnt;
  logic [1:0] sync_q;
  logic [4:0] div_cnt;
  logic       src_val, wake_evt, running, wr_hit;
  logic [4:0] mask;

  always_comb begin
    case (src_q)
      3'd1:    src_val = p3_in[0];
      3'd2:    src_val = p3_in[1];
      3'd3:    src_val = p3_in[2];
      3'd4:    src_val = p3_in[3];
      3'd5:    src_val = p2_in[7];
      3'd6:    src_val = ~|p2_in[3:0];
      3'd7:    src_val = ~|p2_in;
      default: src_val = 1'b0;
    endcase
  end

  assign wake_evt = asleep_q && (src_q != 3'd0) && (sync_q[1] == lvl_q);
  assign running  = !asleep_q && !hold_q;
  assign wr_hit   = wr_en && (wr_bank == REG_BANK) && (wr_addr == REG_ADDR);
  assign mask     = full_q ? {1'b0, {4{d16_q}}} : {{4{d16_q}}, 1'b1};

  assign rd_data  = {flag_q, 7'b0};
  assign wake_rst = hold_q;
  assign asleep   = asleep_q;
  assign sclk_en  = running && ((div_cnt & mask) == mask);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n || !ext_rst_n) begin
      {lvl_q, dly_q, src_q, full_q, d16_q} <= 7'b0100000;
    end else if (wake_evt) begin
      d16_q <= 1'b0;
    end else if (wr_hit) begin
      {lvl_q, dly_q, src_q, full_q, d16_q} <= wr_data[6:0];
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        flag_q <= 1'b0;
    else if (wake_evt) flag_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], src_val};
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n || !ext_rst_n) begin
      asleep_q <= 1'b0;
      hold_q   <= 1'b0;
      hold_cnt <= '0;
    end else if (wake_evt) begin
      asleep_q <= 1'b0;
      hold_q   <= 1'b1;
      hold_cnt <= dly_q ? HW'(LONG_HOLD - 1) : HW'(SHORT_HOLD - 1);
    end else if (hold_q) begin
      if (hold_cnt == '0) hold_q <= 1'b0;
      else                hold_cnt <= hold_cnt - 1'b1;
    end else if (stop_req) begin
      asleep_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n || !ext_rst_n) div_cnt <= '0;
    else if (!running)        div_cnt <= '0;
    else                      div_cnt <= div_cnt + 1'b1;
  end

  assert_clk_gated_asleep_R5: assert property (@(posedge clk) disable iff (!por_n || !ext_rst_n)
    asleep |-> !sclk_en);
  assert_stop_enters_R5: assert property (@(posedge clk) disable iff (!por_n || !ext_rst_n)
    (stop_req && !asleep && !wake_rst) |=> asleep);
  assert_clk_gated_hold_R8: assert property (@(posedge clk) disable iff (!por_n || !ext_rst_n)
    wake_rst |-> !sclk_en);
  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!por_n)
    !$fell(rd_data[7]));
  assert_flag_on_wake_R9: assert property (@(posedge clk) disable iff (!por_n || !ext_rst_n)
    $rose(wake_rst) |-> rd_data[7]);
  assert_div16_cleared_R10: assert property (@(posedge clk) disable iff (!por_n || !ext_rst_n)
    $rose(wake_rst) |-> !d16_q);
  assert_no_wake_src0_R7: assert property (@(posedge clk) disable iff (!por_n || !ext_rst_n)
    (asleep && src_q == 3'd0) |=> asleep);
  assert_rd_low_zero_R1: assert property (@(posedge clk) disable iff (!por_n)
    rd_data[6:0] == 7'd0);
endmodule

// File: tb/stop_wake_ctl_bench.sv
module stop_wake_ctl_bench;
  logic clk = 0, por_n = 0, ext_rst_n = 1, wr_en = 0, stop_req = 0;
  logic [3:0] wr_bank = 0, p3_in = 0;
  logic [7:0] wr_addr = 0, wr_data = 0, p2_in = 0, rd_data;
  logic wake_rst, sclk_en, asleep;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  stop_wake_ctl u_stop_wake_ctl (.clk, .por_n, .ext_rst_n, .wr_en, .wr_bank, .wr_addr,
    .wr_data, .rd_data, .stop_req, .p3_in, .p2_in, .wake_rst, .sclk_en, .asleep);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] b, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_bank = b; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic count_en(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); c += int'(sclk_en); end
  endtask

  task automatic pins(input int src, input bit lvl, input bit act);
    logic [3:0] p3; logic [7:0] p2;
    p3 = {4{lvl}}; p2 = {8{lvl}};
    case (src)
      1, 2, 3, 4: p3[src-1] = act ? lvl : ~lvl;
      5: p2[7] = act ? lvl : ~lvl;
      6: if (lvl) p2 = act ? 8'hF0 : 8'h01; else p2 = act ? 8'h04 : 8'hF0;
      default: if (lvl) p2 = act ? 8'h00 : 8'h80; else p2 = act ? 8'h01 : 8'h00;
    endcase
    p3_in = p3; p2_in = p2;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop_req = 1; @(negedge clk); stop_req = 0;
  endtask

  task automatic do_wake(input int src, input bit lvl, input bit dly, input bit full);
    int c, hi, bad;
    @(negedge clk); pins(src, lvl, 0);
    wr(4'hF, 8'h0B, {1'b0, lvl, dly, 3'(src), full, 1'b1});
    repeat (4) @(negedge clk);
    pulse_stop();
    check(asleep == 1, $sformatf("R5 asleep src%0d", src), asleep, 1);
    bad = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); bad += int'(sclk_en) + int'(wake_rst); end
    check(bad == 0, $sformatf("R6 no false wake src%0d lvl%0d", src, lvl), bad, 0);
    pins(src, lvl, 1);
    @(negedge clk); @(negedge clk);
    check(wake_rst == 0, $sformatf("R6 early wake src%0d", src), wake_rst, 0);
    @(negedge clk);
    check(wake_rst == 1, $sformatf("R6 wake latency src%0d lvl%0d", src, lvl), wake_rst, 1);
    pins(src, lvl, 0);
    hi = 0; bad = 0;
    while (wake_rst && hi < 200) begin bad += int'(sclk_en); hi++; @(negedge clk); end
    check(hi == (dly ? 64 : 2), $sformatf("R8 hold length dly%0d", dly), hi, dly ? 64 : 2);
    check(bad == 0, "R8 clock low in hold", bad, 0);
    check(rd_data == 8'h80, "R9 flag set R1", rd_data, 8'h80);
    count_en(128, c);
    check(c == (full ? 128 : 64), $sformatf("R10 div16 cleared full%0d", full), c, full ? 128 : 64);
  endtask

  initial begin
    int c;
    repeat (3) @(negedge clk); por_n = 1;
    @(negedge clk);
    check(rd_data == 8'h00, "R2 flag after por R1", rd_data, 0);
    count_en(128, c);
    check(c == 64, "R2 default crystal/2", c, 64);
    wr(4'hE, 8'h0B, 8'h03); count_en(128, c);
    check(c == 64, "R3 wrong bank ignored", c, 64);
    wr(4'hF, 8'h0A, 8'h03); count_en(128, c);
    check(c == 64, "R3 wrong addr ignored", c, 64);
    for (int m = 0; m < 4; m++) begin
      int exp;
      exp = 128 / (((m & 2) ? 1 : 2) * ((m & 1) ? 16 : 1));
      wr(4'hF, 8'h0B, 8'(m)); count_en(128, c);
      check(c == exp, $sformatf("R4 pattern mode %0d", m), c, exp);
    end
    for (int s = 1; s < 8; s++)
      for (int l = 0; l < 2; l++)
        for (int d = 0; d < 2; d++)
          do_wake(s, l[0], d[0], l[0] ^ d[0]);
    wr(4'hF, 8'h0B, 8'h03);
    pulse_stop();
    c = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); p3_in = 4'(i); p2_in = 8'(i * 37); c += int'(wake_rst) + int'(!asleep);
    end
    check(c == 0, "R7 source 000 ignores pins", c, 0);
    @(negedge clk); ext_rst_n = 0; @(negedge clk); ext_rst_n = 1;
    check(asleep == 0, "R11 ext reset ends sleep R7", asleep, 0);
    check(rd_data == 8'h80, "R9 flag kept on ext reset", rd_data, 8'h80);
    count_en(128, c);
    check(c == 64, "R11 defaults after ext reset", c, 64);
    @(negedge clk); por_n = 0; @(negedge clk); por_n = 1; @(negedge clk);
    check(rd_data == 8'h00, "R9 por clears flag", rd_data, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule